// File: doc/BRIEF.md
# Execute-Stage Hazard and Forwarding Unit

This block resolves data and control hazards for the execute stage of a five-stage in-order integer pipeline. Each source register of the instruction in EX is compared with the destination register of the instruction in MEM and the one in WB. From that comparison the block gives each operand a 2-bit forward select and the forwarded operand value itself. The value taken from MEM is chosen by that stage's result-source field, so a load in MEM supplies its read data and a jump-and-link supplies its return address. Any other instruction supplies its ALU result.

Load-use dependencies cost no cycles. A consumer may enter EX in the same cycle that its producer load enters MEM, and it takes the load data straight from the MEM-stage register. No fetch or decode stall is raised for it and EX is not flushed. The EX flush output follows only the execute-stage branch mispredict signal. It is combinational, and the surrounding pipeline uses it to clear its EX register on the next clock edge. The block holds no state, and all of its pins are plain control and data signals with no handshake.

Top module: `ex_hazard_unit`

## Requirements
- R1: `flush_ex_o` is 1 exactly when `pc_sel_ex_i` is 1. It stays 0 while a load in MEM writes a register that an EX operand reads.
- R2: An operand gets select 2'b10 (MEM bypass) when its source register is nonzero, equals `mem_rd_i`, and `mem_we_i` is 1.
- R3: An operand gets select 2'b01 (WB result) when its source register is nonzero, equals `wb_rd_i` with `wb_we_i` at 1, and the R2 condition does not hold.
- R4: When MEM and WB both write the operand's nonzero source register, the select is 2'b10.
- R5: The select is 2'b00 (register file) when the source register is x0 or when no writing stage matches it. This holds even if a stage names x0 as its destination.
- R6: `mem_bypass_o` is `mem_rdata_i` when `mem_res_src_i` is 2'b01 (load) and `mem_pc4_i` when it is 2'b10 (jump-and-link). For 2'b00 and 2'b11 it is `mem_alu_i`.
- R7: Each operand output equals the register file value for select 2'b00, `wb_data_i` for 2'b01 and `mem_bypass_o` for 2'b10. A load result therefore reaches a dependent EX operand in the cycle the load is in MEM.
- R8: Each operand is resolved independently. Operand k uses bits [k*5 +: 5] of `rs_ex_i`, bits [k*2 +: 2] of `fwd_sel_o` and bits [k*32 +: 32] of the data buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_sel_ex_i | input | 1 | Execute-stage branch mispredict / redirect |
| rs_ex_i | input | NSRC*AW | Source register indices of the EX instruction |
| rf_data_i | input | NSRC*XLEN | Register file values for the EX operands |
| mem_rd_i | input | AW | Destination register of the MEM instruction |
| mem_we_i | input | 1 | MEM instruction writes a register |
| mem_res_src_i | input | 2 | MEM result source: 00 ALU, 01 load, 10 PC+4, 11 ALU |
| mem_alu_i | input | XLEN | ALU result held in the MEM register |
| mem_rdata_i | input | XLEN | Memory read data for the MEM instruction |
| mem_pc4_i | input | XLEN | PC+4 of the MEM instruction |
| wb_rd_i | input | AW | Destination register of the WB instruction |
| wb_we_i | input | 1 | WB instruction writes a register |
| wb_data_i | input | XLEN | Final result of the WB instruction |
| flush_ex_o | output | 1 | Clear the EX pipeline register at the next edge |
| fwd_sel_o | output | NSRC*2 | Forward select for each operand |
| mem_bypass_o | output | XLEN | MEM-stage bypass value |
| operand_o | output | NSRC*XLEN | Forwarded operand values |

## Verification
A branch mispredict and a load-use bypass can fall in the same cycle. In that case the flush must rise while both operands still resolve to the load data or the WB value. The bench provokes this with directed vectors that set `pc_sel_ex_i` alongside a MEM load whose destination matches one or both EX sources. Further cases come from random vectors that draw register indices from a small range, so that MEM/WB collisions happen often. Every output is compared with select, bypass and operand values that bench functions compute from the requirements.

// File: rtl/ex_hazard_pkg.sv
package ex_hazard_pkg;

  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  typedef enum logic [1:0] {
    RES_ALU  = 2'b00,
    RES_LOAD = 2'b01,
    RES_PC4  = 2'b10,
    RES_ALT  = 2'b11
  } res_src_e;

endpackage

// File: rtl/ex_fwd_select.sv
module ex_fwd_select
  import ex_hazard_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic [AW-1:0] rs_i,
  input  logic [AW-1:0] mem_rd_i,
  input  logic          mem_we_i,
  input  logic [AW-1:0] wb_rd_i,
  input  logic          wb_we_i,
  output logic [1:0]    sel_o
);

  logic rs_live;
  logic hit_mem;
  logic hit_wb;

  assign rs_live = (rs_i != '0);
  assign hit_mem = rs_live && mem_we_i && (mem_rd_i == rs_i);
  assign hit_wb  = rs_live && wb_we_i  && (wb_rd_i  == rs_i);

  // The younger producer (MEM) wins over the older one (WB).
  always_comb begin
    if (hit_mem)     sel_o = FWD_MEM;
    else if (hit_wb) sel_o = FWD_WB;
    else             sel_o = FWD_RF;
  end

endmodule

// File: rtl/ex_mem_bypass_mux.sv
module ex_mem_bypass_mux
  import ex_hazard_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]      res_src_i,
  input  logic [XLEN-1:0] alu_i,
  input  logic [XLEN-1:0] rdata_i,
  input  logic [XLEN-1:0] pc4_i,
  output logic [XLEN-1:0] bypass_o
);

  always_comb begin
    unique case (res_src_e'(res_src_i))
      RES_LOAD: bypass_o = rdata_i;
      RES_PC4:  bypass_o = pc4_i;
      default:  bypass_o = alu_i;
    endcase
  end

endmodule

// File: rtl/ex_operand_mux.sv
module ex_operand_mux
  import ex_hazard_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [1:0]      sel_i,
  input  logic [XLEN-1:0] rf_i,
  input  logic [XLEN-1:0] wb_i,
  input  logic [XLEN-1:0] mem_i,
  output logic [XLEN-1:0] op_o
);

  always_comb begin
    unique case (fwd_sel_e'(sel_i))
      FWD_MEM: op_o = mem_i;
      FWD_WB:  op_o = wb_i;
      default: op_o = rf_i;
    endcase
  end

endmodule

// File: rtl/ex_hazard_unit.sv
module ex_hazard_unit
  import ex_hazard_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input  logic                 pc_sel_ex_i,
  input  logic [NSRC*AW-1:0]   rs_ex_i,
  input  logic [NSRC*XLEN-1:0] rf_data_i,
  input  logic [AW-1:0]        mem_rd_i,
  input  logic                 mem_we_i,
  input  logic [1:0]           mem_res_src_i,
  input  logic [XLEN-1:0]      mem_alu_i,
  input  logic [XLEN-1:0]      mem_rdata_i,
  input  logic [XLEN-1:0]      mem_pc4_i,
  input  logic [AW-1:0]        wb_rd_i,
  input  logic                 wb_we_i,
  input  logic [XLEN-1:0]      wb_data_i,
  output logic                 flush_ex_o,
  output logic [NSRC*2-1:0]    fwd_sel_o,
  output logic [XLEN-1:0]      mem_bypass_o,
  output logic [NSRC*XLEN-1:0] operand_o
);

  localparam int unsigned SELW = 2;

  logic [XLEN-1:0] bypass_val;

  // Only a control-flow redirect in EX empties EX; data hazards never do.
  assign flush_ex_o = pc_sel_ex_i;

  ex_mem_bypass_mux #(.XLEN(XLEN)) bypass_u (
    .res_src_i (mem_res_src_i),
    .alu_i     (mem_alu_i),
    .rdata_i   (mem_rdata_i),
    .pc4_i     (mem_pc4_i),
    .bypass_o  (bypass_val)
  );

  assign mem_bypass_o = bypass_val;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    logic [SELW-1:0] sel_k;

    ex_fwd_select #(.AW(AW)) sel_u (
      .rs_i     (rs_ex_i[k*AW +: AW]),
      .mem_rd_i (mem_rd_i),
      .mem_we_i (mem_we_i),
      .wb_rd_i  (wb_rd_i),
      .wb_we_i  (wb_we_i),
      .sel_o    (sel_k)
    );

    ex_operand_mux #(.XLEN(XLEN)) op_u (
      .sel_i (sel_k),
      .rf_i  (rf_data_i[k*XLEN +: XLEN]),
      .wb_i  (wb_data_i),
      .mem_i (bypass_val),
      .op_o  (operand_o[k*XLEN +: XLEN])
    );

    assign fwd_sel_o[k*SELW +: SELW] = sel_k;
  end

endmodule

// File: rtl/ex_hazard_unit_chk.sv
module ex_hazard_unit_chk #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned AW   = 5,
  parameter int unsigned NSRC = 2
) (
  input logic                 pc_sel_ex_i,
  input logic [NSRC*AW-1:0]   rs_ex_i,
  input logic [NSRC*XLEN-1:0] rf_data_i,
  input logic [AW-1:0]        mem_rd_i,
  input logic                 mem_we_i,
  input logic [1:0]           mem_res_src_i,
  input logic [XLEN-1:0]      mem_alu_i,
  input logic [XLEN-1:0]      mem_rdata_i,
  input logic [XLEN-1:0]      mem_pc4_i,
  input logic [AW-1:0]        wb_rd_i,
  input logic                 wb_we_i,
  input logic [XLEN-1:0]      wb_data_i,
  input logic                 flush_ex_o,
  input logic [NSRC*2-1:0]    fwd_sel_o,
  input logic [XLEN-1:0]      mem_bypass_o,
  input logic [NSRC*XLEN-1:0] operand_o
);

  always_comb begin
    if (!$isunknown({flush_ex_o, pc_sel_ex_i})) begin
      assert_flush_redirect_only_R1: assert (!flush_ex_o || pc_sel_ex_i);
    end
    if (!$isunknown({mem_res_src_i, mem_bypass_o, mem_rdata_i})) begin
      if (mem_res_src_i == 2'b01) begin
        assert_load_bypass_R6: assert (mem_bypass_o == mem_rdata_i);
      end
    end
  end

  for (genvar k = 0; k < NSRC; k++) begin : g_chk
    logic [AW-1:0]   rs_k;
    logic [1:0]      sel_k;
    logic [XLEN-1:0] op_k;
    logic [XLEN-1:0] rf_k;
    assign rs_k  = rs_ex_i[k*AW +: AW];
    assign sel_k = fwd_sel_o[k*2 +: 2];
    assign op_k  = operand_o[k*XLEN +: XLEN];
    assign rf_k  = rf_data_i[k*XLEN +: XLEN];

    always_comb begin
      if (!$isunknown({rs_k, sel_k, mem_rd_i, mem_we_i, wb_rd_i, wb_we_i})) begin
        if (rs_k != '0 && mem_we_i && mem_rd_i == rs_k) begin
          assert_mem_first_R4: assert (sel_k == 2'b10);
        end
        if (rs_k == '0) begin
          assert_x0_from_rf_R5: assert (sel_k == 2'b00);
        end
        if (sel_k == 2'b01) begin
          assert_wb_match_R3: assert (wb_we_i && wb_rd_i == rs_k);
        end
      end
      if (!$isunknown({sel_k, op_k, mem_bypass_o, wb_data_i, rf_k})) begin
        if (sel_k == 2'b10) begin
          assert_op_from_mem_R7: assert (op_k == mem_bypass_o);
        end
        if (sel_k == 2'b00) begin
          assert_op_from_rf_R7: assert (op_k == rf_k);
        end
      end
    end
  end

  logic unused_ok;
  assign unused_ok = ^{mem_alu_i, mem_pc4_i};

endmodule

bind ex_hazard_unit ex_hazard_unit_chk #(
  .XLEN(XLEN), .AW(AW), .NSRC(NSRC)
) chk_i (.*);

// File: tb/ex_hazard_unit_tb_top.sv
module ex_hazard_unit_tb_top;

  localparam int XLEN = 32;
  localparam int AW   = 5;
  localparam int NSRC = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic                 pc_sel_ex;
  logic [NSRC*AW-1:0]   rs_ex;
  logic [NSRC*XLEN-1:0] rf_data;
  logic [AW-1:0]        mem_rd;
  logic                 mem_we;
  logic [1:0]           mem_res_src;
  logic [XLEN-1:0]      mem_alu, mem_rdata, mem_pc4;
  logic [AW-1:0]        wb_rd;
  logic                 wb_we;
  logic [XLEN-1:0]      wb_data;
  logic                 flush_ex;
  logic [NSRC*2-1:0]    fwd_sel;
  logic [XLEN-1:0]      mem_bypass;
  logic [NSRC*XLEN-1:0] operand;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  ex_hazard_unit #(.XLEN(XLEN), .AW(AW), .NSRC(NSRC)) dut_i (
    .pc_sel_ex_i   (pc_sel_ex),
    .rs_ex_i       (rs_ex),
    .rf_data_i     (rf_data),
    .mem_rd_i      (mem_rd),
    .mem_we_i      (mem_we),
    .mem_res_src_i (mem_res_src),
    .mem_alu_i     (mem_alu),
    .mem_rdata_i   (mem_rdata),
    .mem_pc4_i     (mem_pc4),
    .wb_rd_i       (wb_rd),
    .wb_we_i       (wb_we),
    .wb_data_i     (wb_data),
    .flush_ex_o    (flush_ex),
    .fwd_sel_o     (fwd_sel),
    .mem_bypass_o  (mem_bypass),
    .operand_o     (operand)
  );

  function automatic logic [1:0] exp_sel(input logic [AW-1:0] rs);
    if (rs != 0 && mem_we && mem_rd == rs) return 2'b10;
    if (rs != 0 && wb_we && wb_rd == rs)   return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [XLEN-1:0] exp_bypass();
    if (mem_res_src == 2'b01) return mem_rdata;
    if (mem_res_src == 2'b10) return mem_pc4;
    return mem_alu;
  endfunction

  function automatic string sel_tag(input logic [AW-1:0] rs);
    bit m = (rs != 0 && mem_we && mem_rd == rs);
    bit w = (rs != 0 && wb_we && wb_rd == rs);
    if (m && w) return "R4";
    if (m)      return "R2";
    if (w)      return "R3";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic [XLEN-1:0] act,
                       input logic [XLEN-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [XLEN-1:0] byp;
    @(negedge clk);
    #1;
    byp = exp_bypass();
    check("R1 flush", {{(XLEN-1){1'b0}}, flush_ex}, {{(XLEN-1){1'b0}}, pc_sel_ex});
    check("R6 bypass", mem_bypass, byp);
    for (int k = 0; k < NSRC; k++) begin
      logic [AW-1:0] rs;
      logic [1:0]    es;
      logic [XLEN-1:0] eo;
      rs = rs_ex[k*AW +: AW];
      es = exp_sel(rs);
      eo = (es == 2'b10) ? byp : (es == 2'b01) ? wb_data : rf_data[k*XLEN +: XLEN];
      check({sel_tag(rs), " R8 select"}, {30'b0, fwd_sel[k*2 +: 2]}, {30'b0, es});
      check("R7 operand", operand[k*XLEN +: XLEN], eo);
    end
  endtask

  task automatic drive(input bit ps, input logic [AW-1:0] r0, input logic [AW-1:0] r1,
                       input logic [AW-1:0] mrd, input bit mwe, input logic [1:0] src,
                       input logic [AW-1:0] wrd, input bit wwe);
    @(posedge clk);
    pc_sel_ex = ps; rs_ex = {r1, r0};
    mem_rd = mrd; mem_we = mwe; mem_res_src = src;
    wb_rd = wrd; wb_we = wwe;
    rf_data   = {$urandom(), $urandom()};
    mem_alu   = $urandom(); mem_rdata = $urandom();
    mem_pc4   = $urandom(); wb_data   = $urandom();
    check_all();
  endtask

  initial begin
    void'($urandom(32'd1234));
    pc_sel_ex = 0; rs_ex = '0; rf_data = '0; mem_rd = '0; mem_we = 0;
    mem_res_src = 2'b00; mem_alu = '0; mem_rdata = '0; mem_pc4 = '0;
    wb_rd = '0; wb_we = 0; wb_data = '0;
    // Quiet state: nothing forwarded, no flush (R1, R5)
    check_all();
    // R1/R2/R7: load in MEM feeds dependent in EX, no flush
    drive(0, 5'd5, 5'd6, 5'd5, 1, 2'b01, 5'd0, 0);
    // R1: mispredict in the same cycle as a load-use bypass on both operands
    drive(1, 5'd7, 5'd7, 5'd7, 1, 2'b01, 5'd7, 1);
    // R6: jump-and-link value, and the 2'b11 code falls back to ALU
    drive(0, 5'd3, 5'd0, 5'd3, 1, 2'b10, 5'd0, 0);
    drive(0, 5'd3, 5'd0, 5'd3, 1, 2'b11, 5'd0, 0);
    // R4: MEM and WB both write the source; R3: WB only when MEM does not write
    drive(0, 5'd9, 5'd9, 5'd9, 1, 2'b00, 5'd9, 1);
    drive(0, 5'd9, 5'd4, 5'd9, 0, 2'b01, 5'd9, 1);
    // R5: x0 source with x0 destinations that write
    drive(0, 5'd0, 5'd0, 5'd0, 1, 2'b01, 5'd0, 1);
    // R8: operand 0 from MEM, operand 1 from WB
    drive(0, 5'd2, 5'd8, 5'd2, 1, 2'b01, 5'd8, 1);
    // Random mix with small register range for frequent collisions
    for (int i = 0; i < 400; i++) begin
      drive(1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
            5'($urandom_range(0, 3)), 1'($urandom_range(0, 1)));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5 * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule